// File: doc/BRIEF.md
# Asynchronous Static RAM Controller with Parity and Retention Lockout

This controller connects a synchronous request port to an external asynchronous static RAM of 131,072 nine-bit words. A host offers a request with a valid/ready handshake. The request carries a read/write flag, a 17-bit word address and eight data bits. The controller then runs the matching read or write cycle on the RAM pins. It drives an active-low chip select, an active-high chip select, an active-low output enable, an active-low write enable and a shared nine-bit data bus.

The lengths of the cycle phases are given as nanosecond parameters, together with the clock period. Each one is rounded up to whole clock cycles, and turn-around phases get one extra cycle. The ninth RAM bit holds even parity over the data byte. Parity is written on every write and checked on every read, and the result comes back with the read data.

A digital supply-good input controls a low-power retention state. While supply-good is low, the controller finishes any access already in progress, keeps the RAM deselected and accepts no requests. After supply-good returns, it waits out a recovery period before it serves any request. The same recovery period follows reset.

Top module: `sram_ctrl`

## Requirements
- R1: From the cycle after a request is accepted until the chip is deselected, `mem_addr` holds the accepted address.
- R2: The RAM is selected exactly when `mem_ce_n`=0 and `mem_ce`=1. Outside an access, and in reset, `mem_ce_n`=1, `mem_ce`=0, `mem_oe_n`=1 and `mem_we_n`=1.
- R3: A read keeps the chip selected and `mem_oe_n` low for N_RD = max(ceil(T_AA), ceil(T_RC), ceil(T_OE)) + 1 cycles, starting in the cycle after acceptance. In the following cycle `rsp_valid` is high for exactly one cycle, and `rsp_rdata` carries `mem_dq[7:0]` as sampled at the end of the last enable cycle. N_HZ = ceil(T_HZ) + 1 deselected cycles follow before the next request can be accepted.
- R4: A write has one setup cycle with the chip selected and `mem_we_n` high. Then `mem_we_n` is low for N_WP = max(ceil(T_WP), ceil(T_AW), ceil(T_DW), ceil(T_WC) - 2) cycles, and one recovery cycle follows. The write word is driven on `mem_dq` only while `mem_we_n` is low and for the one cycle after it rises.
- R5: The controller never drives `mem_dq` while `mem_oe_n` is low, and `mem_oe_n` and `mem_we_n` are never low together.
- R6: The written bit 8 equals the XOR of data bits 7..0, so each stored word has even parity over nine bits. `rsp_perr` is the XOR of all nine bits read.
- R7: Once supply-good is seen low, `req_ready` is low from the next cycle and the RAM stays deselected. An access already accepted still completes with correct timing and data.
- R8: After reset, and after supply-good returns, `req_ready` stays low for N_REC = ceil(T_REC) cycles, counted from the first clock edge that samples supply-good high.
- R9: A request is accepted only on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the cycle after acceptance until the access has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply good; low requests retention |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write data byte |
| rsp_valid | output | 1 | One-cycle read result strobe |
| rsp_rdata | output | 8 | Read data byte |
| rsp_perr | output | 1 | Parity error on the read word |
| mem_addr | output | 17 | RAM address |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_ce | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq | inout | 9 | RAM data bus, bit 8 is parity |

## Verification
Two situations are hard to reach from the ports.

The first is a supply drop during an access that is already running. The stimulus starts a read and lowers supply-good for a single cycle while output enable is still low. The read must still return correct data, and the recovery count must restart.

The second is a parity error. The RAM itself never corrupts a word. The bench model therefore flips one stored bit behind the controller's back and then reads that address.

Bus contention shows up at the ports only as an unknown value on the shared bus. For that reason the bus is compared against the model's drive value in every cycle in which the model is driving it, including a read that directly follows a write.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_RD_HZ,
    ST_WR_SU,
    ST_WR_PW,
    ST_WR_REC
  } seq_state_t;

  function automatic int ns2cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_parity.sv
module sram_parity #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] wr_data,
  output logic          wr_par,
  input  logic [DW:0]   rd_word,
  output logic          rd_err
);

  // even parity: the full nine-bit word must have an even number of ones
  assign wr_par = ^wr_data;
  assign rd_err = ^rd_word;

endmodule

// File: rtl/sram_recovery.sv
module sram_recovery #(
  parameter int N_REC = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok,
  output logic locked
);

  localparam int NR = (N_REC < 1) ? 1 : N_REC;
  localparam int RW = $clog2(NR + 1);

  logic [RW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !supply_ok) cnt <= RW'(NR);
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign locked = (cnt != '0);

  // R8
  locked_after_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(supply_ok) |-> locked);

endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int AW   = 17,
  parameter int DW   = 8,
  parameter int N_RD = 7,
  parameter int N_HZ = 4,
  parameter int N_WP = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          locked,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          wr_par,
  input  logic [DW-1:0] rd_data,
  input  logic          rd_err,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_perr,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_ce,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          dq_oe,
  output logic [DW:0]   dq_out
);

  localparam int CMAX = imax(imax(N_RD, N_HZ), N_WP);
  localparam int CW   = $clog2(CMAX + 1);

  seq_state_t    state;
  logic [CW-1:0] tcnt;
  logic          accept;

  assign req_ready = (state == ST_IDLE) && !locked;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      tcnt      <= '0;
      mem_addr  <= '0;
      mem_ce_n  <= 1'b1;
      mem_ce    <= 1'b0;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      dq_oe     <= 1'b0;
      dq_out    <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_perr  <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            mem_addr <= req_addr;
            mem_ce_n <= 1'b0;
            mem_ce   <= 1'b1;
            if (req_write) begin
              dq_out <= {wr_par, req_wdata};
              state  <= ST_WR_SU;
            end else begin
              mem_oe_n <= 1'b0;
              tcnt     <= CW'(N_RD - 1);
              state    <= ST_RD;
            end
          end
        end
        ST_RD: begin
          if (tcnt == '0) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= rd_data;
            rsp_perr  <= rd_err;
            mem_oe_n  <= 1'b1;
            mem_ce_n  <= 1'b1;
            mem_ce    <= 1'b0;
            tcnt      <= CW'(N_HZ - 1);
            state     <= ST_RD_HZ;
          end else begin
            tcnt <= tcnt - 1'b1;
          end
        end
        ST_RD_HZ: begin
          if (tcnt == '0) state <= ST_IDLE;
          else            tcnt  <= tcnt - 1'b1;
        end
        ST_WR_SU: begin
          mem_we_n <= 1'b0;
          dq_oe    <= 1'b1;
          tcnt     <= CW'(N_WP - 1);
          state    <= ST_WR_PW;
        end
        ST_WR_PW: begin
          if (tcnt == '0) begin
            mem_we_n <= 1'b1;
            state    <= ST_WR_REC;
          end else begin
            tcnt <= tcnt - 1'b1;
          end
        end
        ST_WR_REC: begin
          dq_oe    <= 1'b0;
          mem_ce_n <= 1'b1;
          mem_ce   <= 1'b0;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4
  we_selected_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_ce_n && mem_ce && mem_oe_n));

  // R5
  no_bus_fight_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !dq_oe);

  // R4
  hold_after_we_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> dq_oe);

  // R3
  rsp_single_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R9
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> !req_ready);

  // R2
  idle_deselect_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_ce_n && !mem_ce && mem_oe_n && mem_we_n));

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW       = 17,
  parameter int DW       = 8,
  parameter int CLK_NS   = 10,
  parameter int T_RC_NS  = 55,
  parameter int T_AA_NS  = 55,
  parameter int T_OE_NS  = 30,
  parameter int T_HZ_NS  = 25,
  parameter int T_WC_NS  = 55,
  parameter int T_WP_NS  = 40,
  parameter int T_AW_NS  = 50,
  parameter int T_DW_NS  = 25,
  parameter int T_REC_NS = 5000000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          supply_ok,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_perr,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_ce,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  inout  wire  [DW:0]   mem_dq
);

  localparam int N_RD  = imax(imax(ns2cyc(T_AA_NS, CLK_NS), ns2cyc(T_RC_NS, CLK_NS)),
                              ns2cyc(T_OE_NS, CLK_NS)) + 1;
  localparam int N_HZ  = ns2cyc(T_HZ_NS, CLK_NS) + 1;
  localparam int N_WP  = imax(imax(imax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_AW_NS, CLK_NS)),
                                   ns2cyc(T_DW_NS, CLK_NS)),
                              imax(ns2cyc(T_WC_NS, CLK_NS) - 2, 1));
  localparam int N_REC = ns2cyc(T_REC_NS, CLK_NS);

  logic          locked;
  logic          wr_par;
  logic          rd_err;
  logic          dq_oe;
  logic [DW:0]   dq_out;

  assign mem_dq = dq_oe ? dq_out : {(DW+1){1'bz}};

  sram_recovery #(.N_REC(N_REC)) u_recovery (
    .clk       (clk),
    .rst       (rst),
    .supply_ok (supply_ok),
    .locked    (locked)
  );

  sram_parity #(.DW(DW)) u_parity (
    .wr_data (req_wdata),
    .wr_par  (wr_par),
    .rd_word (mem_dq),
    .rd_err  (rd_err)
  );

  sram_seq #(
    .AW(AW), .DW(DW), .N_RD(N_RD), .N_HZ(N_HZ), .N_WP(N_WP)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .locked    (locked),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .wr_par    (wr_par),
    .rd_data   (mem_dq[DW-1:0]),
    .rd_err    (rd_err),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_perr  (rsp_perr),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_ce    (mem_ce),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .dq_oe     (dq_oe),
    .dq_out    (dq_out)
  );

endmodule

// File: tb/sram_ctrl_bench.sv
module sram_ctrl_bench;

  localparam int CLK_NS = 10;
  localparam int T_REC  = 1000;

  function automatic int cyc(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int N_RD   = mx(mx(cyc(55), cyc(55)), cyc(30)) + 1;
  localparam int N_HZ   = cyc(25) + 1;
  localparam int N_WP   = mx(mx(mx(cyc(40), cyc(50)), cyc(25)), cyc(55) - 2);
  localparam int N_REC  = cyc(T_REC);
  localparam int RD_END = N_RD + N_HZ;
  localparam int WR_END = N_WP + 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        supply_ok = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  wire         req_ready, rsp_valid, rsp_perr;
  wire  [7:0]  rsp_rdata;
  wire  [16:0] mem_addr;
  wire         mem_ce_n, mem_ce, mem_oe_n, mem_we_n;
  wire  [8:0]  mem_dq;

  always #5 clk = ~clk;

  sram_ctrl #(.CLK_NS(CLK_NS), .T_REC_NS(T_REC)) u_sram_ctrl (
    .clk(clk), .rst(rst), .supply_ok(supply_ok),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_perr(rsp_perr),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce(mem_ce),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq(mem_dq)
  );

  // behavioural RAM
  logic [8:0] ram [int];
  logic [7:0] shadow [int];

  function automatic logic [8:0] ram_rd(input logic [16:0] a);
    if (ram.exists(int'(a))) return ram[int'(a)];
    return 9'h000;
  endfunction

  wire       sel       = !mem_ce_n && mem_ce;
  wire       mdl_drive = sel && !mem_oe_n && mem_we_n;
  wire [8:0] mdl_val   = ram_rd(mem_addr);
  assign mem_dq = mdl_drive ? mdl_val : 9'bz;

  always @(posedge mem_we_n) if (!rst && sel) ram[int'(mem_addr)] = mem_dq;

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // cycle reference model
  int          rec;
  int          bt;
  bit          op_wr;
  bit          acc;
  logic [16:0] m_addr;
  logic [7:0]  m_wdata;

  always @(posedge clk) begin
    if (rst) begin
      rec = N_REC;
      bt  = -1;
    end else begin
      acc = req_valid && (bt < 0) && (rec == 0);
      if (!supply_ok) rec = N_REC;
      else if (rec > 0) rec--;
      if (bt >= 0) begin
        bt++;
        if (bt == (op_wr ? WR_END : RD_END)) bt = -1;
      end
      if (acc) begin
        bt      = 0;
        op_wr   = req_write;
        m_addr  = req_addr;
        m_wdata = req_wdata;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      bit   e_sel, e_oe_n, e_we_n, e_rv;
      logic [8:0] e_rd;
      string tag;
      e_sel  = (bt >= 0) && (op_wr || bt < N_RD);
      e_oe_n = !((bt >= 0) && !op_wr && bt < N_RD);
      e_we_n = !((bt >= 0) && op_wr && bt >= 1 && bt <= N_WP);
      e_rv   = (bt >= 0) && !op_wr && bt == N_RD;
      tag = (bt < 0) ? "R7 idle pins" : (op_wr ? "R4 write pins" : "R3 read pins");
      chk(tag, {mem_ce_n, mem_ce, mem_oe_n, mem_we_n, rsp_valid},
               {!e_sel, e_sel, e_oe_n, e_we_n, e_rv});
      chk("R9 ready", req_ready, (bt < 0) && (rec == 0));
      if (e_sel) chk("R1 address", mem_addr, m_addr);
      if (mdl_drive) chk("R5 bus contention", mem_dq, mdl_val);
      if (bt >= 1 && op_wr && bt <= N_WP + 1)
        chk("R4 write word", mem_dq, {^m_wdata, m_wdata});
      if (e_rv) begin
        e_rd = ram_rd(m_addr);
        chk("R3 read data", rsp_rdata, e_rd[7:0]);
        chk("R6 parity flag", rsp_perr, ^e_rd);
      end
    end
  end

  task automatic send(input bit w, input logic [16:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (w) shadow[int'(a)] = d;
  endtask

  task automatic wr(input logic [16:0] a, input logic [7:0] d);
    send(1'b1, a, d);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic rd(input logic [16:0] a, output logic [7:0] dat, output logic pe);
    send(1'b0, a, 8'h00);
    while (!rsp_valid) @(negedge clk);
    dat = rsp_rdata; pe = rsp_perr;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] dat;
    logic       pe;
    int         cnt;
    repeat (3) @(negedge clk);
    chk("R2 reset pins", {req_ready, mem_ce_n, mem_ce, mem_oe_n, mem_we_n, rsp_valid},
                         6'b010110);
    rst = 1'b0;
    cnt = 0;
    while (!req_ready) begin @(negedge clk); cnt++; end
    chk("R8 power-up recovery cycles", cnt, N_REC);

    // writes, including address boundaries, then read back
    wr(17'h00000, 8'h00);
    wr(17'h1FFFF, 8'hFF);
    wr(17'h0AAAA, 8'h5A);
    wr(17'h15555, 8'h01);
    chk("R6 stored parity of 0x01", ram[int'(17'h15555)][8], 1'b1);
    chk("R6 stored parity of 0x5A", ram[int'(17'h0AAAA)][8], 1'b0);
    rd(17'h1FFFF, dat, pe);
    chk("R3 readback top address", dat, shadow[int'(17'h1FFFF)]);
    chk("R6 clean word flag", pe, 1'b0);
    rd(17'h00000, dat, pe);
    chk("R3 readback address zero", dat, 8'h00);
    rd(17'h15555, dat, pe);
    chk("R3 readback odd byte", dat, 8'h01);
    chk("R6 clean odd word flag", pe, 1'b0);

    // write immediately followed by read of same word (turn-around)
    send(1'b1, 17'h00123, 8'hC3);
    rd(17'h00123, dat, pe);
    chk("R5 read after write data", dat, 8'hC3);

    // parity error injection
    ram[int'(17'h0AAAA)] = ram[int'(17'h0AAAA)] ^ 9'h004;
    rd(17'h0AAAA, dat, pe);
    chk("R6 corrupted word flag", pe, 1'b1);
    chk("R6 corrupted word data", dat, 8'h5A ^ 8'h04);

    // retention entered from idle
    while (!req_ready) @(negedge clk);
    supply_ok = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 17'h1FFFF;
    repeat (20) begin
      @(negedge clk);
      chk("R7 ready low in retention", req_ready, 1'b0);
      chk("R7 chip deselected in retention", {mem_ce_n, mem_ce}, 2'b10);
    end
    supply_ok = 1'b1;
    cnt = 0;
    while (!req_ready) begin @(negedge clk); cnt++; end
    chk("R8 recovery after retention", cnt, N_REC);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    chk("R9 held request served after recovery", rsp_rdata, 8'hFF);

    // supply drop during a read in progress
    send(1'b0, 17'h00123, 8'h00);
    supply_ok = 1'b0;
    @(negedge clk);
    supply_ok = 1'b1;
    while (!rsp_valid) @(negedge clk);
    chk("R7 interrupted read completes", rsp_rdata, 8'hC3);
    cnt = 0;
    while (!req_ready) begin @(negedge clk); cnt++; end
    chk("R8 recovery restarted by drop", cnt >= N_REC - 8, 1'b1);

    rd(17'h00000, dat, pe);
    chk("R3 final readback", dat, 8'h00);
    summary();
    $finish;
  end

endmodule